// File: doc/BRIEF.md
# Calibrated Seconds Prescaler

This block turns a slow oscillator clock enable (nominally 32,768 ticks per second) into a one-clock pulse per second and a pulse that marks the end of each minute. It also applies a digital rate trim. The trim runs over a repeating calibration cycle of minutes. In each affected minute, the first second is made shorter (speeding the clock up) or longer (slowing it down) by a fixed number of oscillator ticks. The minutes affected are a prefix of the cycle whose length is twice the programmed magnitude. The last two minutes of the cycle are never trimmed.

The calibration input is a sign bit above a magnitude field. The block latches it into an active copy only when a calibration cycle ends, so a value written partway through a cycle changes nothing until the next cycle starts.

A separate divider drives a square-wave test tone while the test enable is high. The tone is 512 Hz with default parameters and is independent of the trim. It lets the raw oscillator rate be measured before a trim value is chosen. Downstream seconds, minutes and date counters sit outside this block; only the minute and cycle position needed for the trim is kept here.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `sec_tick`, `min_tick` and `test_out` are 0. The prescale count, the second and minute positions and the active calibration value all start at zero, whatever `cal_val` holds during reset.
- R2: An untrimmed second lasts `SEC_LEN` oscillator ticks. `sec_tick` is high for exactly one clock, in the clock after the tick that ends the second.
- R3: `min_tick` is high in the same clock as the `sec_tick` that ends every `SECS_PER_MIN`-th second, and at no other time.
- R4: `cal_val[MAG_W]` is the direction bit: 1 means fast, 0 means slow. `cal_val[MAG_W-1:0]` is the magnitude N. Only the first second of a minute can be trimmed. That second is trimmed when the minute's index within the cycle (counted from 0) is below 2N.
- R5: With the direction bit at 1, a trimmed second lasts `SEC_LEN - FAST_TRIM` ticks.
- R6: With the direction bit at 0, a trimmed second lasts `SEC_LEN + SLOW_TRIM` ticks.
- R7: A magnitude of 0 trims nothing, whatever the direction bit is.
- R8: However large N is, the last two minutes of a cycle (indices `MINS_PER_CYCLE-2` and `MINS_PER_CYCLE-1`) are never trimmed.
- R9: `cal_val` is sampled only in the clock that ends the last second of a cycle. It governs the whole of the following cycle.
- R10: While `test_en` is 1, `test_out` starts at 0 and inverts after every `TONE_HALF` oscillator ticks. While `test_en` is 0, `test_out` is 0 and the tone divider is cleared.
- R11: `test_out` does not depend on `cal_val` or on the trim state.
- R12: In a clock where `osc_tick` is 0, no count advances: in the next clock `sec_tick` is 0 and `test_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator clock enable, one clock per oscillator period |
| cal_val | input | MAG_W+1 | Direction bit at MSB, trim magnitude below |
| test_en | input | 1 | Enables the test tone |
| sec_tick | output | 1 | One-clock pulse at the end of each second |
| min_tick | output | 1 | One-clock pulse at the end of each minute |
| test_out | output | 1 | Test tone square wave, low when disabled |

## Verification
The oscillator enable is driven in three ways: present every clock, present every other clock, and pseudo-random. Each cycle also opens with an idle burst, which separates counting of oscillator ticks from counting of clocks. Successive cycles carry zero trim, a small fast trim, a small slow trim, and maximum-magnitude trims in both directions. These distinguish the two step sizes, the 2N prefix length and the cap at the last two minutes. A zero-magnitude cycle with the direction bit set shows that the direction alone does nothing. A nonzero value is held on `cal_val` during reset and through most of the first cycle, so any trim applied before a cycle boundary shows up as a miscompare. The test enable toggles independently of cycle boundaries, checking that the tone restarts from zero and ignores the trim.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

   typedef enum logic {
      TRIM_SLOW = 1'b0,
      TRIM_FAST = 1'b1
   } trim_dir_e;

   function automatic int unsigned width_of(int unsigned count);
      return (count <= 2) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick,
   input  logic [CNT_W-1:0] sec_len,
   output logic             sec_end,
   output logic             sec_tick
);

   logic [CNT_W-1:0] cnt;

   assign sec_end = osc_tick && (cnt == (sec_len - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         sec_tick <= 1'b0;
      end else begin
         sec_tick <= sec_end;
         if (sec_end) begin
            cnt <= '0;
         end else if (osc_tick) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rtc_trim_sched.sv
module rtc_trim_sched
   import rtc_trim_pkg::*;
#(
   parameter int unsigned SEC_LEN        = 32768,
   parameter int unsigned SECS_PER_MIN   = 60,
   parameter int unsigned MINS_PER_CYCLE = 64,
   parameter int unsigned FAST_TRIM      = 256,
   parameter int unsigned SLOW_TRIM      = 128,
   parameter int unsigned MAG_W          = 5,
   parameter int unsigned CNT_W          = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_end,
   input  logic [MAG_W:0]   cal_val,
   output logic [CNT_W-1:0] sec_len,
   output logic             min_tick
);

   localparam int unsigned SEC_W  = width_of(SECS_PER_MIN);
   localparam int unsigned MIN_W  = width_of(MINS_PER_CYCLE);
   localparam int unsigned SPAN_W = (((MAG_W + 1) > MIN_W) ? (MAG_W + 1) : MIN_W) + 1;

   localparam logic [SEC_W-1:0]  LAST_SEC = SEC_W'(SECS_PER_MIN - 1);
   localparam logic [MIN_W-1:0]  LAST_MIN = MIN_W'(MINS_PER_CYCLE - 1);
   localparam logic [SPAN_W-1:0] SPAN_CAP = SPAN_W'(MINS_PER_CYCLE - 2);
   localparam logic [CNT_W-1:0]  LEN_NOM  = CNT_W'(SEC_LEN);
   localparam logic [CNT_W-1:0]  LEN_FAST = CNT_W'(SEC_LEN - FAST_TRIM);
   localparam logic [CNT_W-1:0]  LEN_SLOW = CNT_W'(SEC_LEN + SLOW_TRIM);

   logic [SEC_W-1:0]  sec_idx;
   logic [MIN_W-1:0]  min_idx;
   logic [MAG_W:0]    act_cal;
   logic [SPAN_W-1:0] span_dbl;
   logic [SPAN_W-1:0] span;
   logic              end_of_min;
   logic              end_of_cycle;
   logic              trimmed;
   trim_dir_e         dir;

   assign end_of_min   = sec_end && (sec_idx == LAST_SEC);
   assign end_of_cycle = end_of_min && (min_idx == LAST_MIN);

   always_comb begin
      span_dbl = SPAN_W'({act_cal[MAG_W-1:0], 1'b0});
      span     = (span_dbl > SPAN_CAP) ? SPAN_CAP : span_dbl;
      trimmed  = (sec_idx == '0) && (SPAN_W'(min_idx) < span);
      dir      = trim_dir_e'(act_cal[MAG_W]);
      if (!trimmed) begin
         sec_len = LEN_NOM;
      end else if (dir == TRIM_FAST) begin
         sec_len = LEN_FAST;
      end else begin
         sec_len = LEN_SLOW;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_idx  <= '0;
         min_idx  <= '0;
         act_cal  <= '0;
         min_tick <= 1'b0;
      end else begin
         min_tick <= end_of_min;
         if (sec_end) begin
            sec_idx <= end_of_min ? '0 : (sec_idx + 1'b1);
         end
         if (end_of_min) begin
            min_idx <= end_of_cycle ? '0 : (min_idx + 1'b1);
         end
         if (end_of_cycle) begin
            act_cal <= cal_val;
         end
      end
   end

endmodule

// File: rtl/rtc_test_tone.sv
module rtc_test_tone
   import rtc_trim_pkg::*;
#(
   parameter int unsigned TONE_HALF = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   input  logic test_en,
   output logic test_out
);

   generate
      if (TONE_HALF == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               test_out <= 1'b0;
            end else if (!test_en) begin
               test_out <= 1'b0;
            end else if (osc_tick) begin
               test_out <= ~test_out;
            end
         end
      end else begin : g_count
         localparam int unsigned DIV_W = width_of(TONE_HALF);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TONE_HALF - 1);
         logic [DIV_W-1:0] div;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div      <= '0;
               test_out <= 1'b0;
            end else if (!test_en) begin
               div      <= '0;
               test_out <= 1'b0;
            end else if (osc_tick) begin
               if (div == DIV_LAST) begin
                  div      <= '0;
                  test_out <= ~test_out;
               end else begin
                  div <= div + 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
   import rtc_trim_pkg::*;
#(
   parameter int unsigned SEC_LEN        = 32768,
   parameter int unsigned SECS_PER_MIN   = 60,
   parameter int unsigned MINS_PER_CYCLE = 64,
   parameter int unsigned FAST_TRIM      = 256,
   parameter int unsigned SLOW_TRIM      = 128,
   parameter int unsigned TONE_HALF      = 32,
   parameter int unsigned MAG_W          = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           osc_tick,
   input  logic [MAG_W:0] cal_val,
   input  logic           test_en,
   output logic           sec_tick,
   output logic           min_tick,
   output logic           test_out
);

   localparam int unsigned CNT_W = width_of(SEC_LEN + SLOW_TRIM + 1);

   generate
      if (FAST_TRIM + 2 > SEC_LEN) begin : g_bad_fast
         $error("FAST_TRIM must leave a shortened second of at least two ticks");
      end
      if (SECS_PER_MIN < 2) begin : g_bad_spm
         $error("SECS_PER_MIN must be at least 2");
      end
      if (MINS_PER_CYCLE < 3) begin : g_bad_mpc
         $error("MINS_PER_CYCLE must be at least 3");
      end
      if (TONE_HALF < 1) begin : g_bad_tone
         $error("TONE_HALF must be at least 1");
      end
      if (MAG_W < 1) begin : g_bad_mag
         $error("MAG_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] sec_len;
   logic             sec_end;

   rtc_sec_divider #(
      .CNT_W (CNT_W)
   ) i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .sec_len  (sec_len),
      .sec_end  (sec_end),
      .sec_tick (sec_tick)
   );

   rtc_trim_sched #(
      .SEC_LEN        (SEC_LEN),
      .SECS_PER_MIN   (SECS_PER_MIN),
      .MINS_PER_CYCLE (MINS_PER_CYCLE),
      .FAST_TRIM      (FAST_TRIM),
      .SLOW_TRIM      (SLOW_TRIM),
      .MAG_W          (MAG_W),
      .CNT_W          (CNT_W)
   ) i_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_end  (sec_end),
      .cal_val  (cal_val),
      .sec_len  (sec_len),
      .min_tick (min_tick)
   );

   rtc_test_tone #(
      .TONE_HALF (TONE_HALF)
   ) i_tone (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .test_en  (test_en),
      .test_out (test_out)
   );

endmodule

// File: rtl/rtc_trim_prescaler_chk.sv
module rtc_trim_prescaler_chk #(
   parameter int unsigned MAG_W = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic           osc_tick,
   input logic [MAG_W:0] cal_val,
   input logic           test_en,
   input logic           sec_tick,
   input logic           min_tick,
   input logic           test_out
);

   AST_MIN_WITH_SEC: assert property (@(posedge clk) disable iff (!rst_n)
      min_tick |-> sec_tick); // R3

   AST_SEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick); // R2

   AST_SEC_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_tick |=> !sec_tick); // R12

   AST_TONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |=> !test_out); // R10

   AST_TONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && !osc_tick) |=> $stable(test_out)); // R12

   AST_CAL_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(cal_val)); // R4

endmodule

bind rtc_trim_prescaler rtc_trim_prescaler_chk #(.MAG_W(MAG_W)) i_chk (.*);

// File: tb/test_rtc_trim_prescaler.sv
module test_rtc_trim_prescaler;

   localparam int SEC_LEN = 16;
   localparam int SPM     = 3;
   localparam int MPC     = 8;
   localparam int FAST    = 8;
   localparam int SLOW    = 4;
   localparam int HALF    = 2;
   localparam int MAG_W   = 5;

   logic           clk      = 1'b0;
   logic           rst_n    = 1'b0;
   logic           osc_tick = 1'b0;
   logic           test_en  = 1'b0;
   logic [MAG_W:0] cal_val  = '0;
   logic           sec_tick;
   logic           min_tick;
   logic           test_out;

   rtc_trim_prescaler #(
      .SEC_LEN        (SEC_LEN),
      .SECS_PER_MIN   (SPM),
      .MINS_PER_CYCLE (MPC),
      .FAST_TRIM      (FAST),
      .SLOW_TRIM      (SLOW),
      .TONE_HALF      (HALF),
      .MAG_W          (MAG_W)
   ) i_rtc_trim_prescaler (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .cal_val  (cal_val),
      .test_en  (test_en),
      .sec_tick (sec_tick),
      .min_tick (min_tick),
      .test_out (test_out)
   );

   always #2.5ns clk = ~clk;

   int    checks = 0;
   int    fails  = 0;
   string tag    = "R1";
   int    clk_n  = 0;
   int    lfsr   = 16'hACE1;

   // behavioural reference state
   int m_cnt = 0, m_sec = 0, m_min = 0, m_cal = 0, m_tw_cnt = 0;
   bit m_tw = 0, e_sec = 0, e_min = 0, wrapped = 0;

   task automatic check_bit(string what, string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s at clock %0d: got %0b expected %0b", req, what, clk_n, act, exp);
      end
   endtask

   task automatic model_step();
      int len, mag, lim;
      e_sec = 0;
      e_min = 0;
      if (osc_tick) begin
         len = SEC_LEN;
         mag = m_cal & 31;
         lim = 2 * mag;
         if (lim > MPC - 2) lim = MPC - 2;
         if (m_sec == 0 && m_min < lim) len = ((m_cal & 32) != 0) ? SEC_LEN - FAST : SEC_LEN + SLOW;
         m_cnt++;
         if (m_cnt == len) begin
            m_cnt = 0;
            e_sec = 1;
            m_sec++;
            if (m_sec == SPM) begin
               m_sec = 0;
               e_min = 1;
               m_min++;
               if (m_min == MPC) begin
                  m_min   = 0;
                  m_cal   = int'(cal_val);
                  wrapped = 1;
               end
            end
         end
      end
      if (!test_en) begin
         m_tw_cnt = 0;
         m_tw     = 0;
      end else if (osc_tick) begin
         m_tw_cnt++;
         if (m_tw_cnt == HALF) begin
            m_tw_cnt = 0;
            m_tw     = !m_tw;
         end
      end
   endtask

   task automatic one_clock(bit osc, bit ten, logic [MAG_W:0] cal);
      @(negedge clk);
      check_bit("sec_tick", tag, sec_tick, e_sec);
      check_bit("min_tick", tag, min_tick, e_min);
      check_bit("test_out", "R10 R11", test_out, m_tw);
      osc_tick = osc;
      test_en  = ten;
      cal_val  = cal;
      model_step();
      clk_n++;
   endtask

   function automatic bit next_osc(int mode);
      lfsr = (lfsr & 1) ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
      case (mode)
         0:       return 1'b1;
         1:       return clk_n[0];
         default: return (lfsr & 3) != 0;
      endcase
   endfunction

   task automatic run_cycle(string t, logic [MAG_W:0] nxt, int mode);
      logic [MAG_W:0] cur = cal_val;
      int it = 0;
      wrapped = 0;
      tag = {t, " R12"};
      for (int i = 0; i < 20; i++) one_clock(1'b0, ((clk_n / 97) % 3) != 0, cur);
      tag = t;
      while (!wrapped) begin
         if (it == 30) cur = nxt;
         one_clock(next_osc(mode), ((clk_n / 97) % 3) != 0, cur);
         it++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      cal_val = 6'h22;  // nonzero during reset: active value must still be zero (R1)
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check_bit("sec_tick in reset", "R1", sec_tick, 1'b0);
         check_bit("min_tick in reset", "R1", min_tick, 1'b0);
         check_bit("test_out in reset", "R1", test_out, 1'b0);
      end
      rst_n = 1'b1;
      run_cycle("R1 R2 R3 R9 untrimmed first cycle", 6'b100010, 0);
      run_cycle("R4 R5 fast N=2",                    6'b000001, 1);
      run_cycle("R4 R6 slow N=1",                    6'b111111, 2);
      run_cycle("R8 R5 fast capped",                 6'b100000, 2);
      run_cycle("R7 zero magnitude fast sign",       6'b011111, 1);
      run_cycle("R8 R6 slow capped",                 6'b000000, 2);
      run_cycle("R2 R3 back to nominal",             6'b000000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule